// File: doc/BRIEF.md
# Double-Buffered Two-Output PWM Slice

This block is one pulse-width modulation slice. A 16-bit counter runs between zero and a programmable top value. Two compare levels, A and B, each drive one output. An output is high while the count is below its level. The slice can count in two ways. In sawtooth mode it counts up and then restarts. In centre-aligned mode it counts up to the top and then back down, which places each pulse in the middle of the period.

Software writes the top value and the two levels through three independent write strobes, each with its own data bus. A write lands in a shadow register that reads back at once. While the slice is enabled, the shadow values move into the working registers only at a period boundary, so a running waveform never shows a torn period. While the slice is disabled, the working registers follow the shadows every cycle. Disabling the slice freezes the counter in place, and enabling it again resumes from the same count.

Top module: `pwm_slice`

## Requirements
- R1: After reset the count is 0, the direction is up, both outputs are low, the top shadow reads 16'hFFFF and both level shadows read 0.
- R2: In sawtooth mode (`centre_mode`=0), when the slice is enabled, the count rises by one per clock up to the working top value. On the clock after it equals (or exceeds) the top, it returns to 0.
- R3: In centre-aligned mode (`centre_mode`=1), when the slice is enabled, the count rises to the working top value and then falls by one per clock to 0. It then rises again. A full period is 2×top clocks, and a top of 0 holds the count at 0.
- R4: `out_a` is high exactly while the count is below the working A level, and `out_b` behaves the same way for B. A level of 0 keeps the output low. A level above the top keeps it high.
- R5: Each write strobe loads its data into its own shadow register on that clock, and the shadow read port shows it from the next cycle. If several writes arrive before a reload, only the last one survives. A and B can be written alone or in the same cycle.
- R6: In sawtooth mode with the slice enabled, the working top and levels change only on the clock where the count goes from top to 0. They take the shadow values that were held before that clock. A write made on that same clock waits for the following boundary.
- R7: In centre-aligned mode with the slice enabled, the working registers reload only on the clock where the count reaches 0 on its way down, or on every clock when the count stays at 0.
- R8: While `enable` is low, the working top and levels take the shadow value as written on each clock. A write therefore affects the outputs from the next cycle, and pending shadow values are applied as well.
- R9: While `enable` is low, the count and the direction hold. When `enable` is raised again, counting continues from the held count using the working registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the counter; low freezes it and makes writes apply at once |
| centre_mode | input | 1 | 0 sawtooth counting, 1 up/down counting |
| wr_top | input | 1 | Write strobe for the top shadow |
| top_din | input | 16 | Top value to write |
| wr_a | input | 1 | Write strobe for the A level shadow |
| a_din | input | 16 | A level to write |
| wr_b | input | 1 | Write strobe for the B level shadow |
| b_din | input | 16 | B level to write |
| count | output | 16 | Current counter value |
| out_a | output | 1 | Channel A output |
| out_b | output | 1 | Channel B output |
| top_rd | output | 16 | Top shadow readback |
| a_rd | output | 16 | A level shadow readback |
| b_rd | output | 16 | B level shadow readback |

## Verification
Suppose a working register loads at the wrong time. The error first shows on the count or on an output edge within the same period, and it is visible no later than the next boundary. A missed load makes the old duty cycle persist for a whole extra period. A bad direction flag makes the count step the wrong way on the very next clock. A reference model is compared with the count, both outputs and all three readbacks on every cycle, so any such fault is reported in the cycle where it first reaches a port. Random segments move between the two modes and between enabled and disabled states, with writes landing on and off the boundaries.

// File: rtl/pwm_slice.sv
module pwm_slice #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         centre_mode,
  input  logic         wr_top,
  input  logic [W-1:0] top_din,
  input  logic         wr_a,
  input  logic [W-1:0] a_din,
  input  logic         wr_b,
  input  logic [W-1:0] b_din,
  output logic [W-1:0] count,
  output logic         out_a,
  output logic         out_b,
  output logic [W-1:0] top_rd,
  output logic [W-1:0] a_rd,
  output logic [W-1:0] b_rd
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt, act_top, act_a, act_b, sh_top, sh_a, sh_b;
  logic [W-1:0] nxt_cnt;
  logic         down, nxt_down, reload;

  wire [W-1:0] sh_top_n = wr_top ? top_din : sh_top;
  wire [W-1:0] sh_a_n   = wr_a   ? a_din   : sh_a;
  wire [W-1:0] sh_b_n   = wr_b   ? b_din   : sh_b;

  always_comb begin
    nxt_cnt  = cnt;
    nxt_down = down;
    reload   = 1'b0;
    if (!centre_mode) begin
      nxt_down = 1'b0;
      if (cnt >= act_top) begin
        nxt_cnt = '0;
        reload  = 1'b1;
      end else begin
        nxt_cnt = cnt + ONE;
      end
    end else if (!down && cnt < act_top) begin
      nxt_cnt = cnt + ONE;
    end else if (cnt == '0) begin
      nxt_down = 1'b0;
      reload   = 1'b1;
    end else begin
      nxt_cnt  = cnt - ONE;
      nxt_down = (cnt != ONE);
      reload   = (cnt == ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      down    <= 1'b0;
      sh_top  <= '1;
      sh_a    <= '0;
      sh_b    <= '0;
      act_top <= '1;
      act_a   <= '0;
      act_b   <= '0;
    end else begin
      sh_top <= sh_top_n;
      sh_a   <= sh_a_n;
      sh_b   <= sh_b_n;
      if (enable) begin
        cnt  <= nxt_cnt;
        down <= nxt_down;
        if (reload) begin
          act_top <= sh_top;
          act_a   <= sh_a;
          act_b   <= sh_b;
        end
      end else begin
        act_top <= sh_top_n;
        act_a   <= sh_a_n;
        act_b   <= sh_b_n;
      end
    end
  end

  assign count  = cnt;
  assign out_a  = cnt < act_a;
  assign out_b  = cnt < act_b;
  assign top_rd = sh_top;
  assign a_rd   = sh_a;
  assign b_rd   = sh_b;

endmodule

// File: rtl/pwm_slice_chk.sv
module pwm_slice_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable,
  input logic         centre_mode,
  input logic         wr_a,
  input logic [W-1:0] a_din,
  input logic [W-1:0] a_rd,
  input logic [W-1:0] cnt,
  input logic         down,
  input logic [W-1:0] act_top,
  input logic [W-1:0] act_a
);

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !centre_mode && cnt < act_top |=> cnt == $past(cnt) + W'(1));

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !centre_mode && cnt >= act_top |=> cnt == '0);

  a_r3_fall: assert property (@(posedge clk) disable iff (!rst_n)
    enable && centre_mode && down && cnt > W'(1) |=> cnt == $past(cnt) - W'(1));

  a_r5_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a |=> a_rd == $past(a_din));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !centre_mode && cnt < act_top |=> $stable(act_a) && $stable(act_top));

  a_r8_apply: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && wr_a |=> act_a == $past(a_din));

  a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(cnt) && $stable(down));

endmodule

bind pwm_slice pwm_slice_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .centre_mode(centre_mode),
  .wr_a(wr_a), .a_din(a_din), .a_rd(a_rd), .cnt(cnt), .down(down),
  .act_top(act_top), .act_a(act_a)
);

// File: tb/pwm_slice_bench.sv
`timescale 1ns/1ps
module pwm_slice_bench;
  logic clk = 0, rst_n = 0;
  logic enable = 0, centre_mode = 0, wr_top = 0, wr_a = 0, wr_b = 0;
  logic [15:0] top_din = 0, a_din = 0, b_din = 0;
  logic [15:0] count, top_rd, a_rd, b_rd;
  logic out_a, out_b;
  int vectors = 0, errors = 0;
  bit done = 0;

  logic [15:0] m_cnt, m_top, m_a, m_b, s_top, s_a, s_b;
  bit m_down;

  always #4 clk = ~clk;

  pwm_slice u_pwm_slice (.*);

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic [15:0] n_top, n_a, n_b, n_cnt;
    bit n_down, rl;
    n_top = wr_top ? top_din : s_top;
    n_a   = wr_a ? a_din : s_a;
    n_b   = wr_b ? b_din : s_b;
    n_cnt = m_cnt; n_down = m_down; rl = 0;
    if (!centre_mode) begin
      n_down = 0;
      if (m_cnt >= m_top) begin n_cnt = 0; rl = 1; end
      else n_cnt = m_cnt + 1;
    end else if (!m_down && m_cnt < m_top) n_cnt = m_cnt + 1;
    else if (m_cnt == 0) begin n_down = 0; rl = 1; end
    else begin n_cnt = m_cnt - 1; n_down = (n_cnt != 0); rl = (n_cnt == 0); end
    if (enable) begin
      m_cnt = n_cnt; m_down = n_down;
      if (rl) begin m_top = s_top; m_a = s_a; m_b = s_b; end
    end else begin
      m_top = n_top; m_a = n_a; m_b = n_b;
    end
    s_top = n_top; s_a = n_a; s_b = n_b;
  endtask

  task automatic compare_all(input string req);
    chk(req, "count", count, m_cnt);
    chk(req, "out_a", {15'd0, out_a}, {15'd0, m_cnt < m_a});
    chk(req, "out_b", {15'd0, out_b}, {15'd0, m_cnt < m_b});
    chk(req, "top_rd", top_rd, s_top);
    chk(req, "a_rd", a_rd, s_a);
    chk(req, "b_rd", b_rd, s_b);
  endtask

  task automatic cyc(input bit en, input bit cm, input bit wt, input logic [15:0] dt,
                     input bit wa, input logic [15:0] da, input bit wb, input logic [15:0] db,
                     input string req);
    enable = en; centre_mode = cm;
    wr_top = wt; top_din = dt; wr_a = wa; a_din = da; wr_b = wb; b_din = db;
    model_step();
    @(negedge clk);
    compare_all(req);
  endtask

  task automatic idle(input bit en, input bit cm, input int n, input string req);
    for (int i = 0; i < n; i++) cyc(en, cm, 0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_cnt = 0; m_down = 0; m_top = 16'hFFFF; m_a = 0; m_b = 0;
    s_top = 16'hFFFF; s_a = 0; s_b = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "count", count, 0);
    chk("R1", "out_a", {15'd0, out_a}, 0);
    chk("R1", "out_b", {15'd0, out_b}, 0);
    chk("R1", "top_rd", top_rd, 16'hFFFF);
    chk("R1", "a_rd", a_rd, 0);
    chk("R1", "b_rd", b_rd, 0);

    // R8 stopped writes apply next cycle
    cyc(0, 0, 1, 4, 1, 2, 1, 9, "R8");
    chk("R8", "out_a stopped at count 0, level 2", {15'd0, out_a}, 1);
    // R2 sawtooth, R4 level above top stays high
    for (int i = 0; i < 10; i++) begin
      cyc(1, 0, 0, 0, 0, 0, 0, 0, "R2");
      chk("R4", "out_b level above top", {15'd0, out_b}, 1);
    end
    // R6 running write waits for boundary; R5 last write wins
    cyc(1, 0, 0, 0, 1, 3, 0, 0, "R5");
    cyc(1, 0, 0, 0, 1, 0, 1, 0, "R5");
    chk("R5", "a_rd last write", a_rd, 0);
    idle(1, 0, 12, "R6");
    chk("R4", "out_a level zero stays low", {15'd0, out_a}, 0);
    // R9 freeze and resume
    idle(0, 0, 5, "R9");
    idle(1, 0, 3, "R9");
    // R3 centre-aligned, R7 reload at zero
    cyc(0, 1, 1, 3, 1, 2, 1, 1, "R8");
    idle(1, 1, 14, "R3");
    cyc(1, 1, 1, 5, 1, 4, 0, 0, "R7");
    idle(1, 1, 20, "R7");
    cyc(0, 1, 1, 0, 0, 0, 0, 0, "R8");
    idle(1, 1, 4, "R3");

    // constrained random segments
    for (int seg = 0; seg < 150; seg++) begin
      bit cm = $urandom_range(0, 1);
      for (int i = 0; i < 20; i++) begin
        bit en = ($urandom_range(0, 7) != 0);
        bit wt = ($urandom_range(0, 9) == 0);
        bit wa = ($urandom_range(0, 5) == 0);
        bit wb = ($urandom_range(0, 5) == 0);
        string req;
        req = !en ? "R9" : (cm ? "R7" : "R6");
        cyc(en, cm, wt, 16'($urandom_range(0, 12)), wa, 16'($urandom_range(0, 14)),
            wb, 16'($urandom_range(0, 14)), req);
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule